// File: doc/BRIEF.md
# Debug Interface Mode Controller

This block sits on the target side of a two-wire serial debug port and decides what the shared data/reset pin means. Out of power-on reset it is in normal mode, where the pin is an active-low system reset. A rising edge on the debug clock line while the data line is high starts a move into debug mode. From then on the pin's level is kept away from the system reset, and a power-up request goes to the debug domain.

While that domain comes up, the controller counts debug-clock rising edges taken with the data line high. It declares the port ready only after a set number of such edges. It returns to normal mode in two cases. The first is a strobe from the register file that stands for the control/status register being written to zero. The second is both lines held low for a set time on the system clock while hard reset is enabled, which also gives a one-cycle system reset pulse. Both pin inputs pass through two-flop synchronisers before any decision uses them.

Top module: `dbg_mode_ctrl`

## Requirements
- R1: After power-on reset, debugMode, pwrUpReq, dbgReady and hardRstPulse are 0.
- R2: In normal mode, sysResetN follows the synchronised swdIo level, so a low pin drives sysResetN low within 3 clk cycles and a high pin releases it.
- R3: A swdClk rising edge with swdIo high sets debugMode and pwrUpReq to 1 within 4 clk cycles. A rising edge with swdIo low leaves the block in normal mode.
- R4: After entry, dbgReady stays 0 until PWRUP_EDGES further swdClk rising edges have been seen with swdIo high. It is 1 after that many. Rising edges with swdIo low are not counted.
- R5: While debugMode is 1, sysResetN stays 1 whatever the swdIo level.
- R6: A one-cycle ctrlClearStb while debugMode is 1 returns the block to normal mode on the next cycle, with debugMode, pwrUpReq and dbgReady all 0. In normal mode the strobe has no effect.
- R7: With hardRstEn at 1 and both synchronised lines low for HOLD_CYCLES consecutive clk cycles, hardRstPulse is 1 for exactly one cycle. sysResetN is 0 in that cycle, and the block is in normal mode.
- R8: Either line going high restarts the low-hold count, so an interrupted hold gives no pulse.
- R9: With hardRstEn at 0, holding both lines low gives no pulse and leaves the mode unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Power-on reset, active low |
| swdClk | input | 1 | Debug clock line, asynchronous |
| swdIo | input | 1 | Shared debug data / reset pin, asynchronous |
| hardRstEn | input | 1 | Hard reset through the dual-low hold is enabled |
| ctrlClearStb | input | 1 | One-cycle strobe: power-up requests cleared by register write |
| debugMode | output | 1 | 1 when the pin is used as debug data |
| pwrUpReq | output | 1 | Power-up request to the debug domain |
| dbgReady | output | 1 | Debug domain powered and preamble edges counted |
| sysResetN | output | 1 | Gated system reset, active low |
| hardRstPulse | output | 1 | One-cycle hard reset pulse |

## Verification
The hardest state to reach is a low hold that runs to just short of the threshold and then breaks. From the ports, this requires exact control of how long both lines stay low after synchronisation. The bench holds both lines low for ten cycles fewer than the threshold and raises the data line for two cycles. It then holds low for the same span again, and expects no pulse. Only after this does it let the hold run to completion. A second hard-to-reach case is the powering-up state with its count one edge short of the limit. The bench gets there by clocking a counted number of debug edges, mixing in edges taken with the data line low.

// File: rtl/dbg_mode_pkg.sv
package dbg_mode_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL  = 2'd0,
    MODE_POWERUP = 2'd1,
    MODE_DEBUG   = 2'd2
  } modeState_t;

  typedef struct packed {
    logic pwrCntClr;
    logic pwrCntInc;
  } dpStrobes_t;

endpackage

// File: rtl/dbg_mode_sync.sv
module dbg_mode_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  for (genvar b = 0; b < WIDTH; b++) begin : gBit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '0;
      else       chain <= {chain[STAGES-2:0], asyncIn[b]};
    end
    assign syncOut[b] = chain[STAGES-1];
  end

endmodule

// File: rtl/dbg_mode_dp.sv
module dbg_mode_dp
  import dbg_mode_pkg::*;
#(
  parameter int PWRUP_EDGES = 100,
  parameter int HOLD_CYCLES = 20000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       clkS,
  input  logic       ioS,
  input  logic       hardRstEn,
  input  dpStrobes_t stb,
  output logic       riseHigh,
  output logic       pwrDone,
  output logic       holdHit,
  output logic       hardRstPulse
);

  localparam int PW = $clog2(PWRUP_EDGES + 1);
  localparam int HW = $clog2(HOLD_CYCLES + 1);
  localparam logic [PW-1:0] PWR_LIMIT  = PW'(PWRUP_EDGES);
  localparam logic [HW-1:0] HOLD_LIMIT = HW'(HOLD_CYCLES);

  logic          clkPrev;
  logic [PW-1:0] pwrCnt;
  logic [HW-1:0] lowCnt;
  logic          lowCond;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) clkPrev <= 1'b0;
    else       clkPrev <= clkS;
  end

  assign riseHigh = clkS && !clkPrev && ioS;
  assign pwrDone  = (pwrCnt == PWR_LIMIT);

  // counts qualifying preamble edges while the debug domain powers up
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              pwrCnt <= '0;
    else if (stb.pwrCntClr)                 pwrCnt <= '0;
    else if (stb.pwrCntInc && riseHigh && !pwrDone) pwrCnt <= pwrCnt + 1'b1;
  end

  // low-hold detector: restarts whenever a line is high or hard reset is off
  assign lowCond = hardRstEn && !clkS && !ioS;
  assign holdHit = lowCond && (lowCnt == HOLD_LIMIT - 1'b1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    lowCnt <= '0;
    else if (!lowCond)            lowCnt <= '0;
    else if (lowCnt != HOLD_LIMIT) lowCnt <= lowCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) hardRstPulse <= 1'b0;
    else       hardRstPulse <= holdHit;
  end

endmodule

// File: rtl/dbg_mode_fsm.sv
module dbg_mode_fsm
  import dbg_mode_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       riseHigh,
  input  logic       pwrDone,
  input  logic       holdHit,
  input  logic       ctrlClearStb,
  output dpStrobes_t stb,
  output logic       inDebug,
  output logic       ready
);

  modeState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= MODE_NORMAL;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    stb       = '0;
    unique case (state)
      MODE_NORMAL: begin
        stb.pwrCntClr = 1'b1;
        if (riseHigh) stateNext = MODE_POWERUP;
      end
      MODE_POWERUP: begin
        stb.pwrCntInc = 1'b1;
        if (ctrlClearStb) stateNext = MODE_NORMAL;
        else if (pwrDone) stateNext = MODE_DEBUG;
      end
      MODE_DEBUG: begin
        if (ctrlClearStb) stateNext = MODE_NORMAL;
      end
      default: stateNext = MODE_NORMAL;
    endcase
    if (holdHit) stateNext = MODE_NORMAL;
  end

  assign inDebug = (state != MODE_NORMAL);
  assign ready   = (state == MODE_DEBUG);

endmodule

// File: rtl/dbg_mode_ctrl.sv
module dbg_mode_ctrl
  import dbg_mode_pkg::*;
#(
  parameter int PWRUP_EDGES = 100,
  parameter int HOLD_CYCLES = 20000
) (
  input  logic clk,
  input  logic rstN,
  input  logic swdClk,
  input  logic swdIo,
  input  logic hardRstEn,
  input  logic ctrlClearStb,
  output logic debugMode,
  output logic pwrUpReq,
  output logic dbgReady,
  output logic sysResetN,
  output logic hardRstPulse
);

  logic [1:0] pinsS;
  logic       riseHigh, pwrDone, holdHit, inDebug, ready;
  dpStrobes_t stb;

  dbg_mode_sync #(.WIDTH(2), .STAGES(2)) uSync (
    .clk(clk), .rstN(rstN),
    .asyncIn({swdClk, swdIo}),
    .syncOut(pinsS)
  );

  dbg_mode_dp #(.PWRUP_EDGES(PWRUP_EDGES), .HOLD_CYCLES(HOLD_CYCLES)) uDp (
    .clk(clk), .rstN(rstN),
    .clkS(pinsS[1]), .ioS(pinsS[0]),
    .hardRstEn(hardRstEn), .stb(stb),
    .riseHigh(riseHigh), .pwrDone(pwrDone),
    .holdHit(holdHit), .hardRstPulse(hardRstPulse)
  );

  dbg_mode_fsm uFsm (
    .clk(clk), .rstN(rstN),
    .riseHigh(riseHigh), .pwrDone(pwrDone), .holdHit(holdHit),
    .ctrlClearStb(ctrlClearStb),
    .stb(stb), .inDebug(inDebug), .ready(ready)
  );

  assign debugMode = inDebug;
  assign pwrUpReq  = inDebug;
  assign dbgReady  = ready;
  assign sysResetN = !hardRstPulse && (inDebug || pinsS[0]);

endmodule

// File: rtl/dbg_mode_ctrl_chk.sv
module dbg_mode_ctrl_chk (
  input logic clk,
  input logic rstN,
  input logic hardRstEn,
  input logic ctrlClearStb,
  input logic debugMode,
  input logic pwrUpReq,
  input logic dbgReady,
  input logic sysResetN,
  input logic hardRstPulse
);

  AST_DEBUG_MASKS_RESET: assert property (@(posedge clk) disable iff (!rstN)
    debugMode |-> sysResetN);                                   // R5

  AST_READY_IN_DEBUG: assert property (@(posedge clk) disable iff (!rstN)
    dbgReady |-> (debugMode && pwrUpReq));                      // R4

  AST_CLEAR_EXITS: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlClearStb && debugMode) |=> (!debugMode && !dbgReady)); // R6

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    hardRstPulse |=> !hardRstPulse);                            // R7

  AST_PULSE_RESETS: assert property (@(posedge clk) disable iff (!rstN)
    hardRstPulse |-> (!sysResetN && !debugMode));               // R7

  AST_NO_PULSE_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    (!hardRstEn && $past(!hardRstEn) && $past(rstN)) |-> !hardRstPulse); // R9

endmodule

bind dbg_mode_ctrl dbg_mode_ctrl_chk uChk (
  .clk(clk), .rstN(rstN), .hardRstEn(hardRstEn), .ctrlClearStb(ctrlClearStb),
  .debugMode(debugMode), .pwrUpReq(pwrUpReq), .dbgReady(dbgReady),
  .sysResetN(sysResetN), .hardRstPulse(hardRstPulse)
);

// File: tb/dbg_mode_ctrl_test.sv
`timescale 1ns/1ps
module dbg_mode_ctrl_test;

  localparam int PWRUP_EDGES = 8;
  localparam int HOLD_CYCLES = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic swdClk = 1'b0, swdIo = 1'b0, hardRstEn = 1'b0, ctrlClearStb = 1'b0;
  logic debugMode, pwrUpReq, dbgReady, sysResetN, hardRstPulse;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  dbg_mode_ctrl #(.PWRUP_EDGES(PWRUP_EDGES), .HOLD_CYCLES(HOLD_CYCLES)) uut (
    .clk(clk), .rstN(rstN), .swdClk(swdClk), .swdIo(swdIo),
    .hardRstEn(hardRstEn), .ctrlClearStb(ctrlClearStb),
    .debugMode(debugMode), .pwrUpReq(pwrUpReq), .dbgReady(dbgReady),
    .sysResetN(sysResetN), .hardRstPulse(hardRstPulse)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // one debug clock period: rise with given data level, 4 high, 4 low
  task automatic swdEdge(input logic io);
    @(negedge clk); swdIo = io; swdClk = 1'b1;
    waitN(4);
    swdClk = 1'b0;
    waitN(4);
  endtask

  task automatic tReset;
    waitN(1);
    chk("R1 debugMode", debugMode, 0);
    chk("R1 pwrUpReq", pwrUpReq, 0);
    chk("R1 dbgReady", dbgReady, 0);
    chk("R1 hardRstPulse", hardRstPulse, 0);
    rstN = 1'b1;
    waitN(2);
    chk("R1 debugMode after release", debugMode, 0);
  endtask

  task automatic tNormalPin;
    swdIo = 1'b1; waitN(3);
    chk("R2 pin high releases", sysResetN, 1);
    swdIo = 1'b0; waitN(3);
    chk("R2 pin low resets", sysResetN, 0);
    swdIo = 1'b1; waitN(3);
    chk("R2 pin high again", sysResetN, 1);
  endtask

  task automatic tIgnoreLowEdge;
    swdEdge(1'b0);
    chk("R3 low-data edge ignored", debugMode, 0);
    ctrlClearStb = 1'b1; waitN(1); ctrlClearStb = 1'b0; waitN(1);
    chk("R6 strobe in normal no effect", debugMode, 0);
    chk("R6 strobe in normal sysResetN", sysResetN, 0);
  endtask

  task automatic tEnterPowerup;
    @(negedge clk); swdIo = 1'b1; swdClk = 1'b1;
    waitN(4);
    chk("R3 entry debugMode", debugMode, 1);
    chk("R3 entry pwrUpReq", pwrUpReq, 1);
    swdClk = 1'b0; waitN(4);
    swdEdge(1'b0);
    swdEdge(1'b0);
    for (int i = 0; i < PWRUP_EDGES - 1; i++) swdEdge(1'b1);
    chk("R4 not ready one edge short", dbgReady, 0);
    swdEdge(1'b1);
    chk("R4 ready after full count", dbgReady, 1);
  endtask

  task automatic tMask;
    swdIo = 1'b0; waitN(5);
    chk("R5 pin low masked", sysResetN, 1);
    chk("R5 still debug", debugMode, 1);
  endtask

  task automatic tHoldDisabled;
    int pulses = 0;
    hardRstEn = 1'b0; swdClk = 1'b0; swdIo = 1'b0;
    for (int i = 0; i < HOLD_CYCLES + 20; i++) begin
      @(negedge clk); if (hardRstPulse) pulses++;
    end
    chk("R9 no pulse when disabled", pulses, 0);
    chk("R9 mode kept", debugMode, 1);
  endtask

  task automatic tClear;
    ctrlClearStb = 1'b1; waitN(1); ctrlClearStb = 1'b0;
    chk("R6 clear debugMode", debugMode, 0);
    chk("R6 clear pwrUpReq", pwrUpReq, 0);
    chk("R6 clear dbgReady", dbgReady, 0);
  endtask

  task automatic tHardReset;
    int pulses = 0, firstAt = -1, rstAtPulse = 1;
    swdEdge(1'b1);
    chk("R3 re-entry", debugMode, 1);
    hardRstEn = 1'b1; swdClk = 1'b0; swdIo = 1'b0;
    for (int i = 0; i < HOLD_CYCLES + 12; i++) begin
      @(negedge clk);
      if (hardRstPulse) begin
        pulses++;
        if (firstAt < 0) firstAt = i;
        rstAtPulse = sysResetN;
      end
    end
    chk("R7 exactly one pulse", pulses, 1);
    chk("R7 pulse not early", int'(firstAt >= HOLD_CYCLES - 1), 1);
    chk("R7 sysResetN low in pulse", rstAtPulse, 0);
    chk("R7 normal mode after", debugMode, 0);
  endtask

  task automatic tHoldInterrupt;
    int pulses = 0;
    swdIo = 1'b1; waitN(4);
    swdIo = 1'b0;
    for (int i = 0; i < HOLD_CYCLES - 10; i++) begin
      @(negedge clk); if (hardRstPulse) pulses++;
    end
    swdIo = 1'b1; waitN(2); swdIo = 1'b0;
    for (int i = 0; i < HOLD_CYCLES - 10; i++) begin
      @(negedge clk); if (hardRstPulse) pulses++;
    end
    chk("R8 interrupted hold no pulse", pulses, 0);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); if (hardRstPulse) pulses++;
    end
    chk("R8 completed hold pulses once", pulses, 1);
  endtask

  initial begin
    fork
      begin
        tReset();
        tNormalPin();
        tIgnoreLowEdge();
        tEnterPowerup();
        tMask();
        tHoldDisabled();
        tClear();
        tHardReset();
        tHoldInterrupt();
      end
      begin
        repeat (200000) @(posedge clk);
        chk("watchdog expired", 1, 0);
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule